// File: doc/BRIEF.md
# Receive Frame FIFO With Interrupt Handshake

This block queues received message frames for a CPU. Each frame has an identifier, a control word and eight data bytes. Frames wait in arrival order, and the oldest one is always shown on a fixed set of head outputs. The CPU takes the head frame and then clears the frame-available interrupt flag. That clear discards the head entry and moves the next frame up.

Two more interrupt flags report how full the queue is. A warning flag goes up when the queue fills to one entry below capacity. An overflow flag goes up when a frame arrives and there is no room for it. Both flags stay set until the CPU clears them one by one. A global enable input turns the queue on. While the enable is low the queue is emptied and every flag is held low.

Top module: `rx_frame_queue`

## Requirements
- R1: During and right after a synchronous active-low reset, all three flags are low, the queue is empty and the head outputs are zero. Frame writes made during reset are not stored.
- R2: The queue holds at most DEPTH frames (default 6). `irq_avail` is high exactly when at least one frame is held. It rises on the clock edge that stores a frame into an empty queue.
- R3: Frames are read out strictly in arrival order. The head outputs show the oldest held frame.
- R4: A clear strobe on `flag_clr[0]` (the frame-available bit) pops the head frame when the queue is not empty. If frames remain, `irq_avail` stays high and the next frame appears on the head outputs.
- R5: A frame write that arrives while DEPTH frames are held, with no pop in the same cycle, is dropped and sets `irq_ovf`. The held frames are unchanged. Writes keep being dropped until a pop frees a slot.
- R6: `irq_warn` is set on the edge where the held count goes from WARN_LEVEL-1 (default 4) to WARN_LEVEL (default 5).
- R7: `irq_warn` and `irq_ovf` are sticky. A 1 on `flag_clr[1]` clears only the warning flag, and a 1 on `flag_clr[2]` clears only the overflow flag. Clearing the frame-available bit leaves both unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R8: When a frame write and a pop happen in the same cycle on a full queue, the pop is done first. The new frame is accepted, the count stays at DEPTH, and no overflow is raised.
- R9: While `q_enable` is low, the queue is flushed, all three flags are low, and writes and clears are ignored. Enable is expected low after reset.
- R10: A clear on `flag_clr[0]` while the queue is empty has no effect.
- R11: While the queue is empty, the head outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_enable | input | 1 | Queue enable; low flushes the queue and clears the flags |
| wr_valid | input | 1 | Frame write strobe |
| wr_id | input | ID_W | Identifier of the incoming frame |
| wr_ctrl | input | CTRL_W | Control word of the incoming frame |
| wr_data | input | DATA_W | Payload of the incoming frame |
| flag_clr | input | 3 | Write-1-to-clear strobes: bit0 frame-available (pop), bit1 warning, bit2 overflow |
| head_id | output | ID_W | Identifier of the oldest held frame |
| head_ctrl | output | CTRL_W | Control word of the oldest held frame |
| head_data | output | DATA_W | Payload of the oldest held frame |
| irq_avail | output | 1 | At least one frame is held |
| irq_warn | output | 1 | Sticky warning flag (count reached WARN_LEVEL) |
| irq_ovf | output | 1 | Sticky overflow flag (a frame was dropped) |

## Verification
Every state change is registered once. A write, a pop, a flag set, a flag clear or a flush shows on the outputs right after the next rising edge, and the head outputs follow the held count through combinational logic only. The bench applies each cycle's inputs on the falling edge and updates its reference queue model for that edge. It then compares all outputs on the following falling edge, which is one full edge after the stimulus. Directed sequences cover filling to capacity, overflow, the pop-and-write swap on a full queue, the separate clears and the flush. Seeded random traffic follows them.

// File: rtl/rfq_pkg.sv
// Package rfq_pkg
// Shared definitions for the receive frame queue: positions of the
// write-1-to-clear strobes on the flag_clr port.
// Assumes the flag_clr port is exactly FLAG_N bits wide.
package rfq_pkg;
    localparam int FLAG_N    = 3;
    localparam int FLG_AVAIL = 0;
    localparam int FLG_WARN  = 1;
    localparam int FLG_OVF   = 2;

    typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/rfq_store.sv
// Module rfq_store
// Circular storage for DEPTH frames of FRAME_W bits. It writes at the tail
// pointer on push, advances the head pointer on pop, and shows the entry at
// the head pointer on dout.
// Assumes: push and pop were already qualified by the occupancy logic, so
// no overflow or underflow can reach this module. flush resets both pointers.
module rfq_store #(
    parameter int DEPTH   = 6,
    parameter int FRAME_W = 109
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push,
    input  logic               pop,
    input  logic [FRAME_W-1:0] din,
    output logic [FRAME_W-1:0] dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [FRAME_W-1:0] slot [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Purpose: advance the tail and head pointers, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    // One register per slot, loaded only when the tail points at it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Purpose: capture an incoming frame into slot i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (push && wr_ptr == PTR_W'(i)) begin
                slot[i] <= din;
            end
        end
    end

    // Purpose: present the frame at the head pointer.
    always_comb dout = slot[rd_ptr];

    // R2: both pointers stay inside the storage range
    a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr <= LAST) && (rd_ptr <= LAST));
endmodule

// File: rtl/rfq_occupancy.sv
// Module rfq_occupancy
// Tracks how many frames are held. It decides whether a write is accepted
// or dropped and whether a pop request takes effect, and it flags the step
// into the warning level.
// Assumes: one pop and one write at most per cycle. The pop is resolved
// before the write, so a full queue can accept a write in the same cycle
// as a pop.
module rfq_occupancy #(
    parameter int DEPTH      = 6,
    parameter int WARN_LEVEL = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       wr_req,
    input  logic                       pop_req,
    output logic                       push,
    output logic                       pop,
    output logic                       drop,
    output logic                       reach_warn,
    output logic                       nonempty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] PRE_WARN = CNT_W'(WARN_LEVEL - 1);

    logic room;

    // Purpose: qualify pop, then write acceptance, against the current count.
    always_comb begin
        nonempty   = (count != '0);
        pop        = enable && pop_req && nonempty;
        room       = (count != FULL_CNT) || pop;
        push       = enable && wr_req && room;
        drop       = enable && wr_req && !room;
        reach_warn = push && !pop && (count == PRE_WARN);
    end

    // Purpose: hold the frame count; cleared by reset or by disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: count never exceeds capacity
    a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    // R4: an effective pop alone lowers the count by one
    a_r4_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pop_req && nonempty && !wr_req) |=> (count == $past(count) - 1'b1));
    // R8: pop plus write on a full queue keeps it full
    a_r8_swap_full: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_req && pop_req && count == FULL_CNT) |=> (count == FULL_CNT));
    // R10: a pop request on an empty queue leaves it empty without a write
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req && !wr_req) |=> (count == '0));
endmodule

// File: rtl/rfq_irq_flags.sv
// Module rfq_irq_flags
// Keeps the two sticky interrupt flags, warning and overflow. Each flag is
// set by its event strobe and cleared by its own write-1 strobe. If both
// arrive in the same cycle, the set wins.
// Assumes: the event strobes are already qualified by the enable input.
// A low enable forces both flags low.
module rfq_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_warn,
    input  logic set_ovf,
    input  logic clr_warn,
    input  logic clr_ovf,
    output logic warn,
    output logic ovf
);
    // Purpose: sticky warning flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) warn <= 1'b0;
        else if (set_warn)     warn <= 1'b1;
        else if (clr_warn)     warn <= 1'b0;
    end

    // Purpose: sticky overflow flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) ovf <= 1'b0;
        else if (set_ovf)      ovf <= 1'b1;
        else if (clr_ovf)      ovf <= 1'b0;
    end

    // R7: a raised warning survives until its own clear
    a_r7_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (warn && enable && !clr_warn) |=> warn);
    // R7: a raised overflow survives until its own clear
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && enable && !clr_ovf) |=> ovf);
    // R7: a clear with no coincident set drops the overflow flag
    a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !set_ovf) |=> !ovf);
endmodule

// File: rtl/rx_frame_queue.sv
// Module rx_frame_queue
// Top of the receive frame FIFO. Accepted frames are stored in arrival
// order, and the oldest one is shown on the head outputs. A clear of the
// frame-available flag pops the head frame. Sticky warning and overflow
// flags report the fill level.
// Assumes: frames arrive already filtered. flag_clr bits are one-cycle
// write-1 strobes (bit positions from rfq_pkg).
module rx_frame_queue
    import rfq_pkg::*;
#(
    parameter int DEPTH      = 6,
    parameter int WARN_LEVEL = 5,
    parameter int ID_W       = 29,
    parameter int CTRL_W     = 16,
    parameter int DATA_W     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_enable,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_N-1:0] flag_clr,
    output logic [ID_W-1:0]   head_id,
    output logic [CTRL_W-1:0] head_ctrl,
    output logic [DATA_W-1:0] head_data,
    output logic              irq_avail,
    output logic              irq_warn,
    output logic              irq_ovf
);
    localparam int FRAME_W = ID_W + CTRL_W + DATA_W;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    logic               push;
    logic               pop;
    logic               drop;
    logic               reach_warn;
    logic               nonempty;
    logic [CNT_W-1:0]   count;
    logic [FRAME_W-1:0] frame_in;
    logic [FRAME_W-1:0] frame_head;
    logic [FRAME_W-1:0] frame_shown;

    // Purpose: pack the incoming frame fields into one storage word.
    always_comb frame_in = {wr_id, wr_ctrl, wr_data};

    rfq_occupancy #(
        .DEPTH      (DEPTH),
        .WARN_LEVEL (WARN_LEVEL)
    ) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (q_enable),
        .wr_req     (wr_valid),
        .pop_req    (flag_clr[FLG_AVAIL]),
        .push       (push),
        .pop        (pop),
        .drop       (drop),
        .reach_warn (reach_warn),
        .nonempty   (nonempty),
        .count      (count)
    );

    rfq_store #(
        .DEPTH   (DEPTH),
        .FRAME_W (FRAME_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!q_enable),
        .push  (push),
        .pop   (pop),
        .din   (frame_in),
        .dout  (frame_head)
    );

    rfq_irq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (q_enable),
        .set_warn (reach_warn),
        .set_ovf  (drop),
        .clr_warn (flag_clr[FLG_WARN]),
        .clr_ovf  (flag_clr[FLG_OVF]),
        .warn     (irq_warn),
        .ovf      (irq_ovf)
    );

    // Purpose: show the head frame only while something is held.
    always_comb begin
        frame_shown = nonempty ? frame_head : '0;
        {head_id, head_ctrl, head_data} = frame_shown;
        irq_avail = nonempty;
    end

    // R5: a write into a full queue without a pop raises overflow
    a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (q_enable && wr_valid && !flag_clr[FLG_AVAIL] && count == CNT_W'(DEPTH))
        |=> irq_ovf);
    // R5: a dropped write leaves the head frame untouched
    a_r5_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (q_enable && wr_valid && !flag_clr[FLG_AVAIL] && count == CNT_W'(DEPTH))
        |=> $stable(frame_shown));
    // R9: a low enable empties the queue and lowers all flags
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !q_enable |=> (!irq_avail && !irq_warn && !irq_ovf));
    // R2: a write into an empty enabled queue raises frame-available next cycle
    a_r2_avail_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (q_enable && wr_valid && !irq_avail) |=> irq_avail);
    // R11: an empty queue shows a zero head
    a_r11_zero_head: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_avail |-> (frame_shown == '0));
endmodule

// File: tb/sim_rx_frame_queue.sv
module sim_rx_frame_queue;
    localparam int DEPTH = 6;
    localparam int WARN  = 5;
    localparam int ID_W  = 29;
    localparam int CW    = 16;
    localparam int DW    = 64;
    localparam int FW    = ID_W + CW + DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic q_enable = 1'b0;
    logic wr_valid = 1'b0;
    logic [ID_W-1:0] wr_id = '0;
    logic [CW-1:0] wr_ctrl = '0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0] flag_clr = '0;
    logic [ID_W-1:0] head_id;
    logic [CW-1:0] head_ctrl;
    logic [DW-1:0] head_data;
    logic irq_avail, irq_warn, irq_ovf;

    always #2 clk = ~clk;  // 250 MHz

    rx_frame_queue u0 (
        .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .wr_valid(wr_valid),
        .wr_id(wr_id), .wr_ctrl(wr_ctrl), .wr_data(wr_data), .flag_clr(flag_clr),
        .head_id(head_id), .head_ctrl(head_ctrl), .head_data(head_data),
        .irq_avail(irq_avail), .irq_warn(irq_warn), .irq_ovf(irq_ovf)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    logic [FW-1:0] mq[$];
    logic m_warn = 0;
    logic m_ovf = 0;

    task automatic chk(input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] exp_head();
        return (mq.size() > 0) ? mq[0] : '0;
    endfunction

    // Model of one clock edge, computed from the requirements.
    task automatic model_edge(input logic en, input logic wr,
                              input logic [FW-1:0] f, input logic [2:0] clr);
        int old_n;
        bit did_pop, did_push, setw, seto;
        if (!en) begin
            mq.delete();
            m_warn = 0;
            m_ovf = 0;
        end else begin
            old_n = mq.size();
            did_pop = clr[0] && old_n > 0;
            if (did_pop) void'(mq.pop_front());
            did_push = wr && (mq.size() < DEPTH);
            if (did_push) mq.push_back(f);
            seto = wr && !did_push;
            setw = did_push && !did_pop && old_n == WARN - 1;
            if (setw) m_warn = 1; else if (clr[1]) m_warn = 0;
            if (seto) m_ovf = 1; else if (clr[2]) m_ovf = 0;
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, then compare on the next one.
    task automatic cyc(input logic en, input logic wr, input logic [FW-1:0] f,
                       input logic [2:0] clr, input string tag);
        q_enable = en;
        wr_valid = wr;
        {wr_id, wr_ctrl, wr_data} = f;
        flag_clr = clr;
        model_edge(en, wr, f, clr);
        @(posedge clk);
        @(negedge clk);
        chk(tag == "" ? "R2" : tag, "avail", FW'(irq_avail), FW'(mq.size() > 0));
        chk(tag == "" ? "R3" : tag, "head",  {head_id, head_ctrl, head_data}, exp_head());
        chk(tag == "" ? "R6" : tag, "warn",  FW'(irq_warn), FW'(m_warn));
        chk(tag == "" ? "R5" : tag, "ovf",   FW'(irq_ovf), FW'(m_ovf));
    endtask

    function automatic logic [FW-1:0] mkf(input int k);
        return {ID_W'(32'h0ABC_0000 + k), CW'(k * 3 + 1), {DW'(k), 32'hD00D_0000} ^ DW'(k << 40)};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset holds everything clear, writes ignored
        @(negedge clk);
        q_enable = 1;
        wr_valid = 1;
        {wr_id, wr_ctrl, wr_data} = mkf(99);
        repeat (3) @(negedge clk);
        chk("R1", "avail in reset", FW'(irq_avail), '0);
        chk("R1", "head in reset", {head_id, head_ctrl, head_data}, '0);
        chk("R1", "flags in reset", FW'({irq_warn, irq_ovf}), '0);
        rst_n = 1;
        wr_valid = 0;
        q_enable = 0;
        @(negedge clk);
        chk("R1", "avail after reset", FW'(irq_avail), '0);

        // R10 / R11: pop on an empty queue does nothing, head reads zero
        cyc(1, 0, '0, 3'b001, "R10");
        chk("R11", "empty head", {head_id, head_ctrl, head_data}, '0);

        // R2 / R6: fill to capacity, warn at 5
        for (int k = 0; k < DEPTH; k++) begin
            cyc(1, 1, mkf(k), 3'b000, "R2");
            if (k == 0) chk("R2", "avail one edge after first write", FW'(irq_avail), 1);
            if (k == WARN - 2) chk("R6", "warn before level", FW'(irq_warn), 0);
            if (k == WARN - 1) chk("R6", "warn at level", FW'(irq_warn), 1);
        end
        // R5: write when full is dropped, overflow set
        cyc(1, 1, mkf(50), 3'b000, "R5");
        chk("R5", "ovf set", FW'(irq_ovf), 1);
        chk("R5", "head kept", {head_id, head_ctrl, head_data}, mkf(0));
        cyc(1, 1, mkf(51), 3'b000, "R5");
        // R7: clear of avail leaves sticky flags; clear ovf only
        cyc(1, 0, '0, 3'b100, "R7");
        chk("R7", "ovf cleared", FW'(irq_ovf), 0);
        chk("R7", "warn kept", FW'(irq_warn), 1);
        // R8: pop and write on a full queue, no overflow
        cyc(1, 1, mkf(60), 3'b001, "R8");
        chk("R8", "no ovf on swap", FW'(irq_ovf), 0);
        chk("R8", "head advanced", {head_id, head_ctrl, head_data}, mkf(1));
        // R7: set wins over clear (drop while clearing ovf)
        cyc(1, 1, mkf(61), 3'b100, "R7");
        chk("R7", "set beats clear", FW'(irq_ovf), 1);
        // R7: clear warn only
        cyc(1, 0, '0, 3'b010, "R7");
        chk("R7", "warn cleared", FW'(irq_warn), 0);
        chk("R7", "ovf kept", FW'(irq_ovf), 1);
        // R4 / R3: drain in order
        for (int k = 0; k < DEPTH; k++) begin
            cyc(1, 0, '0, 3'b001, "R4");
        end
        chk("R4", "drained", FW'(irq_avail), 0);
        // R9: flush on disable, writes ignored while disabled
        cyc(1, 1, mkf(70), 3'b000, "R9");
        cyc(1, 1, mkf(71), 3'b000, "R9");
        cyc(0, 1, mkf(72), 3'b000, "R9");
        chk("R9", "flushed", FW'({irq_avail, irq_warn, irq_ovf}), '0);
        cyc(0, 1, mkf(73), 3'b000, "R9");
        cyc(1, 0, '0, 3'b000, "R9");
        chk("R9", "nothing kept", FW'(irq_avail), 0);

        // seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            logic en, wr;
            logic [2:0] clr;
            en  = ($urandom % 64) != 0;
            wr  = ($urandom % 100) < 55;
            clr = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 100) < 40};
            cyc(en, wr, {ID_W'($urandom), CW'($urandom), DW'({$urandom, $urandom})}, clr, "");
        end
        summary();
    end
endmodule